// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register memory transfer into a stream of single-word transfers. A caller gives it a 16-bit bitmap of the registers that take part, a 32-bit base address and one of four walk modes. The block then emits one register index and one word address per accepted handshake until every selected register has been covered. It ends with a one-cycle done pulse that carries the updated base value, which a caller may write back to the base register.

The walk mode selects the direction (ascending or descending) and the point at which the address is stepped (before or after the first access). In every mode the registers come out in ascending index order, and the lowest-numbered register always gets the lowest address. A descending walk therefore starts at the bottom of the block it covers and does not start at the base. The block computes addresses and order only. The memory access and the register file access are done elsewhere.

Top module: `blkxfer_addr_seq`

## Requirements
- R1: Mode encoding on `walk_mode_i` is bit 1 = descending and bit 0 = step-before. Code 0 is ascending/after, 1 is ascending/before, 2 is descending/after and 3 is descending/before. For code 0 the first address is the base, and for code 1 it is base+4.
- R2: Let N be the number of set bits in the list. For code 3 the first address is base-4N, and for code 2 it is base-4N+4. All arithmetic is modulo 2^32.
- R3: Transfers are issued in ascending register index. Each transfer's address is the previous one plus 4.
- R4: A sequence makes exactly N transfers, one for each set bit of the list.
- R5: While `xfer_valid_o` is high and `xfer_ready_i` is low, the index and address stay the same. The next transfer is issued only after a cycle in which ready was high.
- R6: `done_o` is high for exactly one cycle. That cycle comes right after the cycle in which the last transfer was accepted.
- R7: In the done cycle, `wb_addr_o` is base+4N for ascending codes and base-4N for descending codes. `wb_valid_o` is high in that cycle only if `wb_en_i` was high with the start pulse.
- R8: An empty list gives no transfers. `done_o` rises in the cycle after the start pulse, and `wb_addr_o` equals the base.
- R9: A start pulse while `busy_o` is high is ignored. The running sequence goes on unchanged.
- R10: After reset, valid, done, writeback-valid and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sequence when the block is idle |
| reg_map_i | input | 16 | Bitmap of the registers that take part |
| base_addr_i | input | 32 | Base address |
| walk_mode_i | input | 2 | Walk mode (see R1) |
| wb_en_i | input | 1 | Asks for a writeback value at the end |
| xfer_valid_o | output | 1 | A transfer is offered |
| xfer_ready_i | input | 1 | The transfer is accepted this cycle |
| xfer_reg_o | output | 4 | Register index of the offered transfer |
| xfer_addr_o | output | 32 | Word address of the offered transfer |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| wb_valid_o | output | 1 | The writeback value is to be used |
| wb_addr_o | output | 32 | Updated base value |
| busy_o | output | 1 | A sequence is in progress |

## Verification
A wrong pending-bitmap state shows up at once in `xfer_reg_o`, as a skipped or repeated index, and one cycle later as a wrong transfer count or an early or late `done_o`. A wrong start address or writeback value shows in the first offered address or in the done cycle. Every offered transfer and every done cycle is compared with a value the bench computes, so any such fault is reported within the same sequence. The ready input is stalled at random, so faults in the hold behaviour appear as index or address changes while ready is low.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
    typedef enum logic [1:0] {
        WALK_UP_AFTER    = 2'd0,
        WALK_UP_BEFORE   = 2'd1,
        WALK_DOWN_AFTER  = 2'd2,
        WALK_DOWN_BEFORE = 2'd3
    } walk_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
    parameter int unsigned VEC_W = 16,
    parameter int unsigned CNT_W = $clog2(VEC_W + 1)
) (
    input  logic [VEC_W-1:0] vec_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < VEC_W; i++) begin
            cnt_o = cnt_o + CNT_W'(vec_i[i]);
        end
    end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
    parameter int unsigned VEC_W = 16,
    parameter int unsigned IDX_W = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [VEC_W-1:0] rest_o
);
    always_comb begin
        idx_o = '0;
        for (int i = VEC_W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        rest_o = vec_i & (vec_i - VEC_W'(1));
    end
endmodule

// File: rtl/blkxfer_addr_plan.sv
module blkxfer_addr_plan
    import blkxfer_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        mode_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] wb_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    walk_mode_e        mode;
    logic [ADDR_W-1:0] span;

    always_comb begin
        mode = walk_mode_e'(mode_i);
        span = ADDR_W'(cnt_i) * STEP;
        case (mode)
            WALK_UP_AFTER: begin
                first_o = base_i;
                wb_o    = base_i + span;
            end
            WALK_UP_BEFORE: begin
                first_o = base_i + STEP;
                wb_o    = base_i + span;
            end
            WALK_DOWN_AFTER: begin
                first_o = base_i - span + STEP;
                wb_o    = base_i - span;
            end
            default: begin
                first_o = base_i - span;
                wb_o    = base_i - span;
            end
        endcase
    end
endmodule

// File: rtl/blkxfer_addr_seq.sv
module blkxfer_addr_seq
    import blkxfer_pkg::*;
#(
    parameter int unsigned LIST_W     = 16,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [LIST_W-1:0]         reg_map_i,
    input  logic [ADDR_W-1:0]         base_addr_i,
    input  logic [1:0]                walk_mode_i,
    input  logic                      wb_en_i,
    output logic                      xfer_valid_o,
    input  logic                      xfer_ready_i,
    output logic [$clog2(LIST_W)-1:0] xfer_reg_o,
    output logic [ADDR_W-1:0]         xfer_addr_o,
    output logic                      done_o,
    output logic                      wb_valid_o,
    output logic [ADDR_W-1:0]         wb_addr_o,
    output logic                      busy_o
);
    localparam int unsigned IDX_W = $clog2(LIST_W);
    localparam int unsigned CNT_W = $clog2(LIST_W + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        seq_state_e        st;
        logic [LIST_W-1:0] pend;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wbv;
        logic              wben;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic [CNT_W-1:0]  sel_cnt;
    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_wb;
    logic [IDX_W-1:0]  cur_idx;
    logic [LIST_W-1:0] pend_rest;

    blkxfer_popcnt #(.VEC_W(LIST_W), .CNT_W(CNT_W)) u_cnt (
        .vec_i (reg_map_i),
        .cnt_o (sel_cnt)
    );

    blkxfer_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base_i  (base_addr_i),
        .mode_i  (walk_mode_i),
        .cnt_i   (sel_cnt),
        .first_o (plan_first),
        .wb_o    (plan_wb)
    );

    blkxfer_lowbit #(.VEC_W(LIST_W), .IDX_W(IDX_W)) u_low (
        .vec_i  (r_q.pend),
        .idx_o  (cur_idx),
        .rest_o (pend_rest)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    r_d.pend = reg_map_i;
                    r_d.addr = plan_first;
                    r_d.wbv  = plan_wb;
                    r_d.wben = wb_en_i;
                    r_d.st   = (|reg_map_i) ? SEQ_RUN : SEQ_FIN;
                end
            end
            SEQ_RUN: begin
                if (xfer_ready_i) begin
                    r_d.pend = pend_rest;
                    r_d.addr = r_q.addr + STEP;
                    if (pend_rest == '0) begin
                        r_d.st = SEQ_FIN;
                    end
                end
            end
            SEQ_FIN: begin
                r_d.st = SEQ_IDLE;
            end
            default: begin
                r_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SEQ_IDLE, pend: '0, addr: '0, wbv: '0, wben: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign xfer_valid_o = (r_q.st == SEQ_RUN);
    assign xfer_reg_o   = cur_idx;
    assign xfer_addr_o  = r_q.addr;
    assign done_o       = (r_q.st == SEQ_FIN);
    assign wb_valid_o   = done_o && r_q.wben;
    assign wb_addr_o    = r_q.wbv;
    assign busy_o       = (r_q.st != SEQ_IDLE);

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_reg_o) && $stable(xfer_addr_o))); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && xfer_ready_i && $countones(r_q.pend) > 1) |=> (xfer_addr_o == $past(xfer_addr_o) + STEP)); // R3
    AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && xfer_ready_i && $countones(r_q.pend) > 1) |=> (xfer_valid_o && xfer_reg_o > $past(xfer_reg_o))); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && xfer_ready_i && $countones(r_q.pend) == 1) |=> (done_o && !xfer_valid_o)); // R6
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && reg_map_i == '0) |=> (done_o && !xfer_valid_o)); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !xfer_ready_i && start_i) |=> $stable(xfer_addr_o)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!xfer_valid_o && !done_o && !wb_valid_o)); // R10
endmodule

// File: tb/blkxfer_addr_seq_tb.sv
module blkxfer_addr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] reg_map_i = '0;
    logic [31:0] base_addr_i = '0;
    logic [1:0]  walk_mode_i = '0;
    logic        wb_en_i = 1'b0;
    logic        xfer_ready_i = 1'b0;
    logic        xfer_valid_o, done_o, wb_valid_o, busy_o;
    logic [3:0]  xfer_reg_o;
    logic [31:0] xfer_addr_o, wb_addr_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    blkxfer_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_map_i(reg_map_i),
        .base_addr_i(base_addr_i), .walk_mode_i(walk_mode_i), .wb_en_i(wb_en_i),
        .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
        .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o), .busy_o(busy_o)
    );

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [31:0] low_addr(input logic [31:0] b, input logic [1:0] md, input int n);
        logic [31:0] span = 32'(n) * 32'd4;
        if (md[1]) return b - span + (md[0] ? 32'd0 : 32'd4);
        return b + (md[0] ? 32'd4 : 32'd0);
    endfunction

    function automatic logic [31:0] wb_val(input logic [31:0] b, input logic [1:0] md, input int n);
        logic [31:0] span = 32'(n) * 32'd4;
        return md[1] ? b - span : b + span;
    endfunction

    function automatic int kth_reg(input logic [15:0] m, input int k);
        int seen = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_seq(input logic [15:0] m, input logic [31:0] b, input logic [1:0] md,
                           input bit wb, input bit inject);
        int n = popc(m);
        int k = 0;
        int guard = 0;
        bit prev_stall = 1'b0;
        start_i = 1'b1; reg_map_i = m; base_addr_i = b; walk_mode_i = md; wb_en_i = wb;
        xfer_ready_i = 1'b0;
        @(negedge clk);
        forever begin
            start_i = 1'b0;
            reg_map_i = $urandom; base_addr_i = $urandom; walk_mode_i = 2'($urandom); wb_en_i = 1'($urandom);
            if (k == n) begin
                if (n == 0) chk(done_o && !xfer_valid_o, "R8 empty done", 32'(done_o), 32'd1);
                chk(done_o == 1'b1, "R6 done after last", 32'(done_o), 32'd1);
                chk(wb_addr_o == wb_val(b, md, n), "R7 wb value", wb_addr_o, wb_val(b, md, n));
                chk(wb_valid_o == wb, "R7 wb valid", 32'(wb_valid_o), 32'(wb));
                if (n == 0) chk(wb_addr_o == b, "R8 base kept", wb_addr_o, b);
                break;
            end
            chk(xfer_valid_o && !done_o, "R4 valid during run", 32'(xfer_valid_o), 32'd1);
            chk(32'(xfer_reg_o) == 32'(kth_reg(m, k)), prev_stall ? "R5 R3 index" : "R3 index",
                32'(xfer_reg_o), 32'(kth_reg(m, k)));
            chk(xfer_addr_o == low_addr(b, md, n) + 32'(k) * 32'd4,
                md[1] ? "R2 address" : "R1 address",
                xfer_addr_o, low_addr(b, md, n) + 32'(k) * 32'd4);
            if (inject && k == n / 2) start_i = 1'b1; // R9: start while busy
            xfer_ready_i = ($urandom_range(0, 3) != 0);
            prev_stall = !xfer_ready_i;
            if (xfer_ready_i) k++;
            guard++;
            if (guard > 400) begin
                chk(1'b0, "R4 sequence hung", 32'(k), 32'(n));
                break;
            end
            @(negedge clk);
        end
        xfer_ready_i = 1'b0;
        start_i = 1'b0;
        @(negedge clk);
        chk(!done_o && !busy_o && !xfer_valid_o, inject ? "R9 R6 back to idle" : "R6 back to idle",
            32'({done_o, busy_o, xfer_valid_o}), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk(!xfer_valid_o && !done_o && !wb_valid_o && !busy_o, "R10 reset state",
            32'({xfer_valid_o, done_o, wb_valid_o, busy_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R10 idle after reset", 32'(busy_o), 32'd0);
        for (int md = 0; md < 4; md++) begin
            run_seq(16'h0000, 32'h0000_1000, 2'(md), 1'b1, 1'b0);
            run_seq(16'hFFFF, 32'h0000_2000, 2'(md), 1'b1, 1'b0);
            run_seq(16'h8001, 32'h0000_0008, 2'(md), 1'b0, 1'b1);
            run_seq(16'h0400, 32'hFFFF_FFF8, 2'(md), 1'b1, 1'b0);
        end
        for (int t = 0; t < 60; t++) begin
            logic [15:0] m = 16'($urandom) & 16'($urandom);
            run_seq(m, {$urandom} & 32'hFFFF_FFFC, 2'($urandom), 1'($urandom), (t % 3) == 0);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule